// File: doc/BRIEF.md
# Two-Dimensional Strided DMA Address Generator

This block produces the memory address stream for one DMA channel. A transfer engine pulses an advance input once per moved word, and the generator answers with the next address. Bus cycles and data movement happen elsewhere. Software programs the generator through a simple register-write port and then arms it.

In linear mode a block is a run of consecutive words that starts at a programmed base. When the block ends, the address returns to the base and a block interrupt is raised. In circular operation the generator keeps running, which forms a ring buffer. In one-shot operation it stops, so software can point it at a fresh buffer before the old data is overwritten.

In strided mode each block boundary moves the block start forward by a programmed stride, which may be negative. The gaps this leaves between blocks can later receive packet headers. A second counter tracks how many blocks have been produced. After the last block a completion interrupt is raised and the generator halts until it is armed again. Base and stride writes made during a run are held back and take effect only at the next block boundary. Interrupt status bits stay set until software writes a one to clear them.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset `addr` is 0, and `addr_valid`, `irq_blk` and `irq_done` are all low.
- R2: A write to select 4 with data bit 0 set arms the generator. On the next cycle `addr` equals the base register (select 0) and `addr_valid` is high. Data bit 1 of the same write selects strided mode when 1 and linear mode when 0. Data bit 2 selects circular operation when 1.
- R3: Inside a block, each cycle with `adv` high while `addr_valid` is high raises `addr` by WORD_BYTES (default 4) on the next cycle.
- R4: A block holds (select 2 value + 1) words. The advance on the last word of a block is a boundary, and it sets `irq_blk` on the next cycle.
- R5: In linear mode a boundary reloads `addr` with the base register. With circular operation `addr_valid` stays high. With one-shot operation `addr_valid` goes low.
- R6: In strided mode a boundary that is not the last one loads `addr` with the previous block start plus the stride register (select 1), modulo 2^ADDR_W.
- R7: In strided mode the boundary of block number (select 3 value + 1) sets `irq_done` and drops `addr_valid`. `addr` then holds its last value, and later advances have no effect until the generator is armed again.
- R8: Writes to the base, stride or count registers never change the address of the block in progress. A base written during a strided run replaces the stride step at the next boundary. A stride written during a run is used from the next boundary on.
- R9: `irq_blk` (clear bit 0) and `irq_done` (clear bit 1) stay set until a write to select 5 has a one in that bit. A zero in that bit leaves the status unchanged. A new event in the same cycle as a clear wins over the clear.
- R10: While `addr_valid` is low, `adv` changes neither `addr` nor `addr_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 base, 1 stride, 2 words per block minus one, 3 blocks minus one, 4 control, 5 interrupt clear |
| wr_data | input | ADDR_W | Write data |
| adv | input | 1 | Advance request from the transfer engine, one per word |
| addr | output | ADDR_W | Current transfer address |
| addr_valid | output | 1 | Generator is running and `addr` is live |
| irq_blk | output | 1 | Sticky block-boundary interrupt status |
| irq_done | output | 1 | Sticky strided-run completion status |
| irq_any | output | 1 | OR of the interrupt status bits |

## Verification
Every internal counter of this block is visible at the ports within one block length. A word counter that is off by one moves the boundary, so `addr` jumps back or strides one advance early or late. A wrong block counter makes `irq_done` and the fall of `addr_valid` arrive a whole block early or late. A stale block start or a mishandled shadowed base shows as a wrong address on the first advance after the boundary. The bench compares every output against a behavioural model on every cycle, so each of these faults is reported on the first cycle it appears.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  // register select codes on the write port
  typedef enum logic [2:0] {
    SEL_BASE   = 3'd0,
    SEL_STRIDE = 3'd1,
    SEL_WORDS  = 3'd2,
    SEL_BLOCKS = 3'd3,
    SEL_CTRL   = 3'd4,
    SEL_ICLR   = 3'd5
  } reg_sel_e;

  // control word bit positions
  localparam int CTRL_ARM    = 0;
  localparam int CTRL_STRIDE = 1;
  localparam int CTRL_CIRC   = 2;

  // interrupt status bit positions (also clear-mask positions)
  localparam int IRQ_BLK  = 0;
  localparam int IRQ_DONE = 1;
  localparam int NUM_IRQ  = 2;

  typedef struct packed {
    logic strided;
    logic circular;
  } mode_t;

endpackage

// File: rtl/dma2d_rst_sync.sv
module dma2d_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/dma2d_regs.sv
module dma2d_regs
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_sel,
  input  logic [ADDR_W-1:0]  wr_data,
  input  logic               running,
  input  logic               blk_end,
  input  logic [NUM_IRQ-1:0] evt_set,
  output logic [ADDR_W-1:0]  base_q,
  output logic [ADDR_W-1:0]  stride_q,
  output logic [CNT_W-1:0]   words_q,
  output logic [CNT_W-1:0]   blocks_q,
  output mode_t              mode_q,
  output logic               arm,
  output logic               base_pend_q,
  output logic [NUM_IRQ-1:0] irq_q
);

  logic [ADDR_W-1:0] base_d, stride_d;
  logic [CNT_W-1:0]  words_d, blocks_d;
  mode_t             mode_d;
  logic              base_pend_d;
  logic              hit_base, hit_stride, hit_words, hit_blocks, hit_ctrl, hit_iclr;
  logic [NUM_IRQ-1:0] irq_d;

  // address decode
  always_comb begin
    hit_base   = wr_en && (wr_sel == SEL_BASE);
    hit_stride = wr_en && (wr_sel == SEL_STRIDE);
    hit_words  = wr_en && (wr_sel == SEL_WORDS);
    hit_blocks = wr_en && (wr_sel == SEL_BLOCKS);
    hit_ctrl   = wr_en && (wr_sel == SEL_CTRL);
    hit_iclr   = wr_en && (wr_sel == SEL_ICLR);
    arm        = hit_ctrl && wr_data[CTRL_ARM];
  end

  // configuration next state
  always_comb begin
    base_d   = base_q;
    stride_d = stride_q;
    words_d  = words_q;
    blocks_d = blocks_q;
    mode_d   = mode_q;
    if (hit_base)   base_d   = wr_data;
    if (hit_stride) stride_d = wr_data;
    if (hit_words)  words_d  = wr_data[CNT_W-1:0];
    if (hit_blocks) blocks_d = wr_data[CNT_W-1:0];
    if (hit_ctrl) begin
      mode_d.strided  = wr_data[CTRL_STRIDE];
      mode_d.circular = wr_data[CTRL_CIRC];
    end
  end

  // pending-base flag: a base written mid-run overrides the next stride step
  always_comb begin
    base_pend_d = base_pend_q;
    if (arm) begin
      base_pend_d = 1'b0;
    end else if (hit_base && running) begin
      base_pend_d = 1'b1;
    end else if (blk_end) begin
      base_pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      stride_q <= '0;
      words_q  <= '0;
      blocks_q <= '0;
      mode_q   <= '0;
    end else if (wr_en) begin
      base_q   <= base_d;
      stride_q <= stride_d;
      words_q  <= words_d;
      blocks_q <= blocks_d;
      mode_q   <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_pend_q <= 1'b0;
    end else if (wr_en || blk_end) begin
      base_pend_q <= base_pend_d;
    end
  end

  // sticky interrupt status, one slice per source; set wins over clear
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    logic clr_i;
    assign clr_i    = hit_iclr && wr_data[i];
    assign irq_d[i] = evt_set[i] || (irq_q[i] && !clr_i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irq_q[i] <= 1'b0;
      end else if (evt_set[i] || clr_i) begin
        irq_q[i] <= irq_d[i];
      end
    end
  end

endmodule

// File: rtl/dma2d_seq.sv
module dma2d_seq
  import dma2d_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              adv,
  input  mode_t             mode,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] stride,
  input  logic [CNT_W-1:0]  words,
  input  logic [CNT_W-1:0]  blocks,
  input  logic              base_pend,
  output logic [ADDR_W-1:0] addr_q,
  output logic              run_q,
  output logic              blk_end,
  output logic              done_evt
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] addr_d, start_q, start_d, next_start;
  logic [CNT_W-1:0]  wcnt_q, wcnt_d, wlast_q, wlast_d;
  logic [CNT_W-1:0]  bcnt_q, bcnt_d, blast_q, blast_d;
  logic              run_d, step, last_word, last_block, upd;

  always_comb begin
    step       = run_q && adv && !arm;
    last_word  = (wcnt_q == wlast_q);
    last_block = (bcnt_q == blast_q);
    blk_end    = step && last_word;
    done_evt   = blk_end && mode.strided && last_block;
    next_start = base_pend ? base : (start_q + stride);
    upd        = arm || step;
  end

  always_comb begin
    addr_d  = addr_q;
    start_d = start_q;
    wcnt_d  = wcnt_q;
    wlast_d = wlast_q;
    bcnt_d  = bcnt_q;
    blast_d = blast_q;
    run_d   = run_q;
    if (arm) begin
      addr_d  = base;
      start_d = base;
      wcnt_d  = '0;
      bcnt_d  = '0;
      wlast_d = words;
      blast_d = blocks;
      run_d   = 1'b1;
    end else if (step) begin
      if (!last_word) begin
        addr_d = addr_q + STEP;
        wcnt_d = wcnt_q + 1'b1;
      end else begin
        wcnt_d  = '0;
        wlast_d = words;
        if (!mode.strided) begin
          addr_d  = base;
          start_d = base;
          run_d   = mode.circular;
        end else if (last_block) begin
          run_d = 1'b0;
        end else begin
          addr_d  = next_start;
          start_d = next_start;
          bcnt_d  = bcnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      start_q <= '0;
      wcnt_q  <= '0;
      wlast_q <= '0;
      bcnt_q  <= '0;
      blast_q <= '0;
      run_q   <= 1'b0;
    end else if (upd) begin
      addr_q  <= addr_d;
      start_q <= start_d;
      wcnt_q  <= wcnt_d;
      wlast_q <= wlast_d;
      bcnt_q  <= bcnt_d;
      blast_q <= blast_d;
      run_q   <= run_d;
    end
  end

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_valid,
  output logic              irq_blk,
  output logic              irq_done,
  output logic              irq_any
);

  logic              rst_sync_n;
  logic [ADDR_W-1:0] base_q, stride_q;
  logic [CNT_W-1:0]  words_q, blocks_q;
  mode_t             mode_q;
  logic              arm, base_pend_q, blk_end, done_evt, run_q;
  logic [NUM_IRQ-1:0] irq_q, evt_set;

  dma2d_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign evt_set[IRQ_BLK]  = blk_end;
  assign evt_set[IRQ_DONE] = done_evt;

  dma2d_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .running     (run_q),
    .blk_end     (blk_end),
    .evt_set     (evt_set),
    .base_q      (base_q),
    .stride_q    (stride_q),
    .words_q     (words_q),
    .blocks_q    (blocks_q),
    .mode_q      (mode_q),
    .arm         (arm),
    .base_pend_q (base_pend_q),
    .irq_q       (irq_q)
  );

  dma2d_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .arm       (arm),
    .adv       (adv),
    .mode      (mode_q),
    .base      (base_q),
    .stride    (stride_q),
    .words     (words_q),
    .blocks    (blocks_q),
    .base_pend (base_pend_q),
    .addr_q    (addr),
    .run_q     (run_q),
    .blk_end   (blk_end),
    .done_evt  (done_evt)
  );

  assign addr_valid = run_q;
  assign irq_blk    = irq_q[IRQ_BLK];
  assign irq_done   = irq_q[IRQ_DONE];
  assign irq_any    = |irq_q;

endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int ADDR_W     = 16,
  parameter int WORD_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [2:0]        wr_sel,
  input logic [ADDR_W-1:0] wr_data,
  input logic              adv,
  input logic [ADDR_W-1:0] addr,
  input logic              addr_valid,
  input logic              irq_blk,
  input logic              irq_done,
  input logic              blk_end
);

  logic arm_w, clr_blk, clr_done;
  assign arm_w    = wr_en && (wr_sel == 3'd4) && wr_data[0];
  assign clr_blk  = wr_en && (wr_sel == 3'd5) && wr_data[0];
  assign clr_done = wr_en && (wr_sel == 3'd5) && wr_data[1];

  assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arm_w |=> addr_valid);

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && adv && !arm_w && !blk_end) |=>
      (addr_valid && (addr == $past(addr) + ADDR_W'(WORD_BYTES))));

  assert_blk_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |=> irq_blk);

  assert_done_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_done) |-> !addr_valid);

  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !arm_w) |=> $stable(addr));

  assert_blk_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_blk && !clr_blk) |=> irq_blk);

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_done && !clr_done) |=> irq_done);

  assert_idle_adv_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_valid && !arm_w) |=> (!addr_valid && $stable(addr)));

endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(
  .ADDR_W     (ADDR_W),
  .WORD_BYTES (WORD_BYTES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .adv        (adv),
  .addr       (addr),
  .addr_valid (addr_valid),
  .irq_blk    (irq_blk),
  .irq_done   (irq_done),
  .blk_end    (blk_end)
);

// File: tb/sim_dma2d_addr_gen.sv
`timescale 1ns/1ps
module sim_dma2d_addr_gen;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_sel = 3'd0;
  logic [AW-1:0] wr_data = '0;
  logic          adv = 1'b0;
  logic [AW-1:0] addr;
  logic          addr_valid, irq_blk, irq_done, irq_any;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;
  bit finished = 1'b0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  dma2d_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .adv(adv), .addr(addr), .addr_valid(addr_valid), .irq_blk(irq_blk),
    .irq_done(irq_done), .irq_any(irq_any)
  );

  // ---------------- behavioural reference model ----------------
  logic [AW-1:0] m_base, m_stride, m_addr, m_start;
  int  m_words, m_blocks, m_wi, m_wn, m_bi, m_bn;
  bit  m_strided, m_circ, m_pend, m_run, m_ib, m_id;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_base = '0; m_stride = '0; m_addr = '0; m_start = '0;
      m_words = 0; m_blocks = 0; m_wi = 0; m_wn = 0; m_bi = 0; m_bn = 0;
      m_strided = 0; m_circ = 0; m_pend = 0; m_run = 0; m_ib = 0; m_id = 0;
    end else begin
      bit arm_now, moving, boundary, finish_now, was_run;
      arm_now    = wr_en && wr_sel == 3'd4 && wr_data[0];
      moving     = m_run && adv && !arm_now;
      boundary   = moving && (m_wi == m_wn);
      finish_now = boundary && m_strided && (m_bi == m_bn);
      was_run    = m_run;
      if (arm_now) begin
        m_addr = m_base; m_start = m_base; m_wi = 0; m_bi = 0;
        m_wn = m_words; m_bn = m_blocks; m_run = 1;
      end else if (moving) begin
        if (!boundary) begin
          m_addr = m_addr + 16'd4; m_wi++;
        end else begin
          m_wi = 0; m_wn = m_words;
          if (!m_strided) begin
            m_addr = m_base; m_start = m_base; m_run = m_circ;
          end else if (finish_now) begin
            m_run = 0;
          end else begin
            m_start = m_pend ? m_base : m_start + m_stride;
            m_addr = m_start; m_bi++;
          end
        end
      end
      if (arm_now) m_pend = 0;
      else if (wr_en && wr_sel == 3'd0 && was_run) m_pend = 1;
      else if (boundary) m_pend = 0;
      if (wr_en) begin
        case (wr_sel)
          3'd0: m_base = wr_data;
          3'd1: m_stride = wr_data;
          3'd2: m_words = int'(wr_data[7:0]);
          3'd3: m_blocks = int'(wr_data[7:0]);
          3'd4: begin m_strided = wr_data[1]; m_circ = wr_data[2]; end
          3'd5: begin
            if (wr_data[0]) m_ib = 0;
            if (wr_data[1]) m_id = 0;
          end
          default: ;
        endcase
      end
      if (boundary) m_ib = 1;
      if (finish_now) m_id = 1;
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      checks++;
      if (addr !== m_addr || addr_valid !== m_run || irq_blk !== m_ib ||
          irq_done !== m_id || irq_any !== (m_ib | m_id)) begin
        errors++;
        $display("FAIL %s model: addr=%h valid=%b ib=%b id=%b expected addr=%h valid=%b ib=%b id=%b",
                 phase, addr, addr_valid, irq_blk, irq_done, m_addr, m_run, m_ib, m_id);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus helpers (called at a negedge) ----------------
  task automatic wr(input logic [2:0] sel, input logic [AW-1:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic go(input int n);
    adv = 1'b1;
    repeat (n) @(negedge clk);
    adv = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cmp_on = 1'b1;
    // R1 reset state
    chk("R1 addr", addr, 16'h0);
    chk("R1 valid", {15'd0, addr_valid}, 16'd0);
    chk("R1 irq", {14'd0, irq_done, irq_blk}, 16'd0);

    // linear one-shot
    phase = "R2";
    wr(3'd0, 16'h0100); wr(3'd2, 16'd3); wr(3'd4, 16'h0001);
    chk("R2 addr", addr, 16'h0100);
    chk("R2 valid", {15'd0, addr_valid}, 16'd1);
    phase = "R3";
    go(1);
    chk("R3 step", addr, 16'h0104);
    phase = "R4";
    go(3);
    chk("R4 irq_blk", {15'd0, irq_blk}, 16'd1);
    chk("R5 reload", addr, 16'h0100);
    chk("R5 oneshot valid", {15'd0, addr_valid}, 16'd0);
    phase = "R10";
    go(3);
    chk("R10 addr", addr, 16'h0100);
    chk("R10 valid", {15'd0, addr_valid}, 16'd0);
    phase = "R9";
    wr(3'd5, 16'h0002);
    chk("R9 zero bit keeps", {15'd0, irq_blk}, 16'd1);
    wr(3'd5, 16'h0001);
    chk("R9 clear", {15'd0, irq_blk}, 16'd0);

    // linear circular with shadowed base
    phase = "R5";
    wr(3'd2, 16'd1); wr(3'd4, 16'h0005);
    go(1);
    chk("R5 circ step", addr, 16'h0104);
    phase = "R8";
    wr(3'd0, 16'h0200);
    chk("R8 base write mid-block", addr, 16'h0104);
    go(1);
    chk("R8 reload new base", addr, 16'h0200);
    chk("R5 circ valid", {15'd0, addr_valid}, 16'd1);
    go(2);
    chk("R5 wrap again", addr, 16'h0200);
    wr(3'd5, 16'h0003);

    // strided run with stride change
    phase = "R6";
    wr(3'd0, 16'h1000); wr(3'd1, 16'h0040); wr(3'd2, 16'd2); wr(3'd3, 16'd2);
    wr(3'd4, 16'h0003);
    go(3);
    chk("R6 stride step", addr, 16'h1040);
    go(1);
    phase = "R8";
    wr(3'd1, 16'h0080);
    chk("R8 stride write mid-block", addr, 16'h1044);
    go(2);
    chk("R8 new stride at boundary", addr, 16'h10C0);
    phase = "R7";
    go(3);
    chk("R7 done", {15'd0, irq_done}, 16'd1);
    chk("R7 halted", {15'd0, addr_valid}, 16'd0);
    chk("R7 addr holds", addr, 16'h10C8);
    go(2);
    chk("R7 ignored adv", addr, 16'h10C8);

    // negative stride, base override at boundary
    phase = "R8";
    wr(3'd5, 16'h0003);
    wr(3'd0, 16'h3000); wr(3'd1, 16'hFFF0); wr(3'd2, 16'd0); wr(3'd3, 16'd3);
    wr(3'd4, 16'h0003);
    go(1);
    chk("R6 negative stride", addr, 16'h2FF0);
    wr(3'd0, 16'h5000);
    chk("R8 base pending", addr, 16'h2FF0);
    go(1);
    chk("R8 base override", addr, 16'h5000);
    go(1);
    chk("R6 stride after override", addr, 16'h4FF0);
    go(1);
    chk("R7 done after four blocks", {15'd0, irq_done}, 16'd1);

    // random traffic against the model
    phase = "R3 R4 R6 R9 random";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 8) begin
        wr(3'($urandom_range(0, 5)), 16'($urandom_range(0, 65535)) & 16'hFF0F);
      end else if (r < 12) begin
        wr(3'd4, 16'($urandom_range(0, 7)) | 16'h0001);
      end else begin
        adv = ($urandom_range(0, 3) != 0);
        @(negedge clk);
        adv = 1'b0;
      end
    end

    @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule